// File: doc/BRIEF.md
# Oversampled Serial Receiver with Word Queue

This block recovers asynchronous serial frames from a single input line. A separate baud generator supplies a one-cycle tick sixteen times per bit period; the receiver uses these ticks to confirm the start bit at its centre and then sample each following bit at its centre. The data field is seven or eight bits long and arrives least significant bit first. An optional parity bit may follow the data. That bit is not checked. It is stored with the word so that the host can judge it. A low stop bit marks the stored word with a framing flag.

Each finished word goes into a small queue with eight entries. The host always sees the oldest entry on the read port and removes it with a one-cycle read strobe. A configuration input can reduce the queue to a single holding register, in which each new word replaces the one before it. While the shutdown input is high, the receiver ignores frames. In that state any change of level on the line sets an activity flag, which a read strobe clears.

Top module: `uart_rx_queue`

## Requirements
- R1: A low level seen on a tick starts a frame only if the line is still low at the 8th tick after that one. If it is not, the receiver goes back to idle and stores nothing.
- R2: Data bits are sampled at mid-bit, least significant bit first. In 8-bit mode (`cfg_len8`=1) all eight bits are returned. In 7-bit mode (`cfg_len8`=0) the seven bits fill `rd_data[6:0]` and `rd_data[7]` reads 0.
- R3: With `cfg_par_en`=1 the bit that follows the data is stored unchanged on `rd_par`, whether it matches the data or not. With `cfg_par_en`=0 no such bit is taken and `rd_par` reads 0.
- R4: `rd_ferr` is 1 for a word whose stop bit sampled low, and 0 for a word whose stop bit sampled high.
- R5: With `cfg_fifo_en`=1, up to 8 words are held and returned oldest first. `rd_valid` is 1 exactly while at least one word is held. A high `rd_en` removes the head word.
- R6: A word that arrives while 8 words are held is dropped. The held words and their order are unchanged.
- R7: With `cfg_fifo_en`=0 at most one word is held, and each newly received word replaces it.
- R8: While `cfg_shdn`=1, no frame is received. Any transition on `rx` sets `rx_activity`, and a read strobe clears it. Transitions while `cfg_shdn`=0 never set it.
- R9: After reset `rd_valid` and `rx_activity` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| rx | input | 1 | Asynchronous serial line, idle high |
| cfg_len8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| cfg_par_en | input | 1 | 1: a parity bit follows the data |
| cfg_fifo_en | input | 1 | 1: 8-entry queue, 0: single holding register |
| cfg_shdn | input | 1 | 1: shutdown, reception stopped, activity watch on |
| rd_en | input | 1 | Remove the head word; also clears `rx_activity` |
| rd_data | output | 8 | Head word data |
| rd_par | output | 1 | Head word received parity bit |
| rd_ferr | output | 1 | Head word framing flag |
| rd_valid | output | 1 | At least one word held |
| rx_activity | output | 1 | Line transition seen during shutdown |

## Verification
The bench builds the block with its defaults: a queue depth of 8, 16 ticks per bit and a two-stage input synchronizer. It drives a tick every second clock, so one bit lasts 32 clocks. At depth 8, nine back-to-back frames are enough to fill the queue and show that the ninth word is dropped. The short bit period makes it cheap to test a start glitch of four ticks, a stop bit that is cut short, and line activity during shutdown.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic              ferr;
    logic              par;
    logic [DATA_W-1:0] data;
  } rx_word_t;
endpackage

// File: rtl/rxq_sync.sv
module rxq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_raw,
  output logic rx_s,
  output logic rx_edge
);
  logic [STAGES-1:0] pipe;
  logic              last;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe <= '1;
      last <= 1'b1;
    end else begin
      pipe <= {pipe[STAGES-2:0], rx_raw};
      last <= pipe[STAGES-1];
    end
  end

  assign rx_s    = pipe[STAGES-1];
  assign rx_edge = pipe[STAGES-1] ^ last;
endmodule

// File: rtl/rxq_framer.sv
module rxq_framer
  import rxq_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     tick,
  input  logic     rx_s,
  input  logic     len8,
  input  logic     par_en,
  input  logic     shdn,
  output logic     push,
  output rx_word_t word
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} fr_state_t;

  fr_state_t         st;
  logic [CW-1:0]     cnt;
  logic [2:0]        nbit;
  logic [DATA_W-1:0] sh;
  logic              pbit;
  logic [2:0]        last_bit;

  assign last_bit = len8 ? 3'd7 : 3'd6;

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= S_IDLE;
      cnt  <= '0;
      nbit <= '0;
      sh   <= '0;
      pbit <= 1'b0;
      push <= 1'b0;
      word <= '0;
    end else begin
      push <= 1'b0;
      if (shdn) begin
        st  <= S_IDLE;
        cnt <= '0;
      end else if (tick) begin
        case (st)
          S_IDLE: begin
            if (!rx_s) begin
              st  <= S_START;
              cnt <= '0;
            end
          end
          S_START: begin
            if (cnt == MID) begin
              cnt  <= '0;
              nbit <= '0;
              st   <= rx_s ? S_IDLE : S_DATA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_DATA: begin
            if (cnt == LAST) begin
              cnt  <= '0;
              sh   <= {rx_s, sh[DATA_W-1:1]};
              nbit <= nbit + 1'b1;
              if (nbit == last_bit) st <= par_en ? S_PAR : S_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_PAR: begin
            if (cnt == LAST) begin
              cnt  <= '0;
              pbit <= rx_s;
              st   <= S_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_STOP: begin
            if (cnt == LAST) begin
              cnt       <= '0;
              st        <= S_IDLE;
              push      <= 1'b1;
              word.data <= len8 ? sh : {1'b0, sh[DATA_W-1:1]};
              word.par  <= par_en & pbit;
              word.ferr <= ~rx_s;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         fifo_en,
  input  logic                         push,
  input  rx_word_t                     word,
  input  logic                         pop,
  output rx_word_t                     head,
  output logic                         not_empty,
  output logic [$clog2(DEPTH+1)-1:0]   occ
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_N = CW'(DEPTH);

  rx_word_t      mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr, rd_nxt, wr_addr;
  logic [CW-1:0] cnt, cnt_nxt;
  logic          do_pop, full, wr_en;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign do_pop = pop && (cnt != '0);
  assign full   = (cnt == FULL_N);
  assign rd_nxt = do_pop ? ptr_inc(rd_ptr) : rd_ptr;

  always_comb begin
    wr_en   = 1'b0;
    wr_addr = wr_ptr;
    if (push) begin
      if (!fifo_en) begin
        wr_en   = 1'b1;
        wr_addr = rd_nxt;
      end else if (!full || do_pop) begin
        wr_en = 1'b1;
      end
    end
  end

  always_comb begin
    if (wr_en && !fifo_en) cnt_nxt = CW'(1);
    else                   cnt_nxt = cnt + CW'(wr_en) - CW'(do_pop);
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr    <= '0;
      wr_ptr    <= '0;
      cnt       <= '0;
      not_empty <= 1'b0;
    end else begin
      rd_ptr    <= rd_nxt;
      cnt       <= cnt_nxt;
      not_empty <= (cnt_nxt != '0);
      if (wr_en) wr_ptr <= fifo_en ? ptr_inc(wr_ptr) : ptr_inc(rd_nxt);
    end
  end

  assign head = mem[rd_ptr];
  assign occ  = cnt;
endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue
  import rxq_pkg::*;
#(
  parameter int DEPTH       = 8,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       baud_tick,
  input  logic       rx,
  input  logic       cfg_len8,
  input  logic       cfg_par_en,
  input  logic       cfg_fifo_en,
  input  logic       cfg_shdn,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  output logic       rd_par,
  output logic       rd_ferr,
  output logic       rd_valid,
  output logic       rx_activity
);
  localparam int CW = $clog2(DEPTH + 1);

  logic          rx_s, rx_edge, push;
  rx_word_t      new_word, head;
  logic [CW-1:0] occ;

  rxq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .rx_raw(rx), .rx_s(rx_s), .rx_edge(rx_edge)
  );

  rxq_framer #(.OVS(OVS)) u_frm (
    .clk(clk), .rst(rst), .tick(baud_tick), .rx_s(rx_s), .len8(cfg_len8),
    .par_en(cfg_par_en), .shdn(cfg_shdn), .push(push), .word(new_word)
  );

  rxq_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst), .fifo_en(cfg_fifo_en), .push(push), .word(new_word),
    .pop(rd_en), .head(head), .not_empty(rd_valid), .occ(occ)
  );

  always_ff @(posedge clk) begin
    if (rst)                       rx_activity <= 1'b0;
    else if (cfg_shdn && rx_edge)  rx_activity <= 1'b1;
    else if (rd_en)                rx_activity <= 1'b0;
  end

  assign rd_data = head.data;
  assign rd_par  = head.par;
  assign rd_ferr = head.ferr;
endmodule

// File: rtl/uart_rx_queue_chk.sv
module uart_rx_queue_chk #(
  parameter int DEPTH = 8
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       cfg_shdn,
  input logic                       cfg_fifo_en,
  input logic                       rd_en,
  input logic                       rd_valid,
  input logic                       rx_activity,
  input logic [7:0]                 rd_data,
  input logic [$clog2(DEPTH+1)-1:0] occ,
  input logic                       push
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_N = CW'(DEPTH);

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    occ <= FULL_N);

  assert_full_drop_R6: assert property (@(posedge clk) disable iff (rst)
    (cfg_fifo_en && occ == FULL_N && push && !rd_en) |=> (occ == FULL_N && $stable(rd_data)));

  assert_pop_one_R5: assert property (@(posedge clk) disable iff (rst)
    (cfg_fifo_en && rd_en && occ != '0 && !push) |=> (occ == $past(occ) - 1'b1));

  assert_valid_match_R5: assert property (@(posedge clk) disable iff (rst)
    rd_valid == (occ != '0));

  assert_hold_depth_R7: assert property (@(posedge clk) disable iff (rst)
    (!cfg_fifo_en && occ <= CW'(1)) |=> occ <= CW'(1));

  assert_shdn_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (cfg_shdn && $past(cfg_shdn)) |=> !$rose(rd_valid));

  assert_act_source_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_activity) |-> $past(cfg_shdn));
endmodule

bind uart_rx_queue uart_rx_queue_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .cfg_shdn(cfg_shdn), .cfg_fifo_en(cfg_fifo_en),
  .rd_en(rd_en), .rd_valid(rd_valid), .rx_activity(rx_activity),
  .rd_data(rd_data), .occ(u_store.occ), .push(u_frm.push)
);

// File: tb/uart_rx_queue_bench.sv
`timescale 1ns/1ps
module uart_rx_queue_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       baud_tick;
  logic       rx = 1'b1;
  logic       cfg_len8 = 1'b1, cfg_par_en = 1'b0, cfg_fifo_en = 1'b1, cfg_shdn = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       rd_par, rd_ferr, rd_valid, rx_activity;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  always_ff @(posedge clk) baud_tick <= rst ? 1'b0 : ~baud_tick;

  uart_rx_queue u_uart_rx_queue (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .rx(rx), .cfg_len8(cfg_len8),
    .cfg_par_en(cfg_par_en), .cfg_fifo_en(cfg_fifo_en), .cfg_shdn(cfg_shdn),
    .rd_en(rd_en), .rd_data(rd_data), .rd_par(rd_par), .rd_ferr(rd_ferr),
    .rd_valid(rd_valid), .rx_activity(rx_activity)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one bit lasts 16 ticks, a tick every second clock
  task automatic line(input logic b, input int ticks);
    rx = b;
    repeat (2 * ticks) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic par_v, input logic stop_hi);
    line(1'b0, 16);
    for (int i = 0; i < (cfg_len8 ? 8 : 7); i++) line(d[i], 16);
    if (cfg_par_en) line(par_v, 16);
    if (stop_hi) line(1'b1, 16);
    else begin
      line(1'b0, 10);
      line(1'b1, 6);
    end
    line(1'b1, 16);
  endtask

  task automatic pull(input string req, input logic [7:0] d, input logic p, input logic f);
    chk(req, "valid", rd_valid, 1);
    chk(req, "data", rd_data, d);
    chk(req, "par", rd_par, p);
    chk(req, "ferr", rd_ferr, f);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R9", "valid after reset", rd_valid, 0);
    chk("R9", "activity after reset", rx_activity, 0);
  endtask

  task automatic t_eight_bit;
    cfg_len8 = 1'b1; cfg_par_en = 1'b0;
    send(8'hA5, 1'b0, 1'b1);
    pull("R2", 8'hA5, 1'b0, 1'b0);
    send(8'h3C, 1'b0, 1'b1);
    pull("R3", 8'h3C, 1'b0, 1'b0);
    chk("R5", "empty after reads", rd_valid, 0);
  endtask

  task automatic t_seven_parity;
    cfg_len8 = 1'b0; cfg_par_en = 1'b1;
    send(8'h5A, 1'b1, 1'b1);
    pull("R3", 8'h5A, 1'b1, 1'b0);
    send(8'h01, 1'b0, 1'b1);
    pull("R3", 8'h01, 1'b0, 1'b0);
    send(8'hFF, 1'b1, 1'b1);
    pull("R2", 8'h7F, 1'b1, 1'b0);
    cfg_len8 = 1'b1; cfg_par_en = 1'b0;
  endtask

  task automatic t_framing;
    send(8'h81, 1'b0, 1'b0);
    pull("R4", 8'h81, 1'b0, 1'b1);
    send(8'h42, 1'b0, 1'b1);
    pull("R4", 8'h42, 1'b0, 1'b0);
    chk("R4", "no spurious word", rd_valid, 0);
  endtask

  task automatic t_glitch;
    line(1'b0, 4);
    line(1'b1, 40);
    chk("R1", "glitch stored nothing", rd_valid, 0);
    send(8'hC3, 1'b0, 1'b1);
    pull("R1", 8'hC3, 1'b0, 1'b0);
  endtask

  task automatic t_order;
    send(8'h11, 1'b0, 1'b1);
    send(8'h22, 1'b0, 1'b1);
    send(8'h33, 1'b0, 1'b1);
    pull("R5", 8'h11, 1'b0, 1'b0);
    pull("R5", 8'h22, 1'b0, 1'b0);
    pull("R5", 8'h33, 1'b0, 1'b0);
    chk("R5", "empty after three", rd_valid, 0);
  endtask

  task automatic t_overflow;
    for (int i = 0; i < 9; i++) send(8'h10 + 8'(i), 1'b0, 1'b1);
    for (int i = 0; i < 8; i++) pull("R6", 8'h10 + 8'(i), 1'b0, 1'b0);
    chk("R6", "ninth word dropped", rd_valid, 0);
  endtask

  task automatic t_holding;
    cfg_fifo_en = 1'b0;
    send(8'h44, 1'b0, 1'b1);
    send(8'h55, 1'b0, 1'b1);
    pull("R7", 8'h55, 1'b0, 1'b0);
    chk("R7", "single entry", rd_valid, 0);
    cfg_fifo_en = 1'b1;
  endtask

  task automatic t_shutdown;
    chk("R8", "no activity outside shutdown", rx_activity, 0);
    cfg_shdn = 1'b1;
    line(1'b1, 4);
    line(1'b0, 3);
    line(1'b1, 3);
    chk("R8", "activity set", rx_activity, 1);
    send(8'h66, 1'b0, 1'b1);
    chk("R8", "no word in shutdown", rd_valid, 0);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
    chk("R8", "activity cleared by read", rx_activity, 0);
    cfg_shdn = 1'b0;
    line(1'b1, 4);
    send(8'h77, 1'b0, 1'b1);
    chk("R8", "edges after shutdown ignored", rx_activity, 0);
    pull("R8", 8'h77, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    t_reset();
    t_eight_bit();
    t_seven_parity();
    t_framing();
    t_glitch();
    t_order();
    t_overflow();
    t_holding();
    t_shutdown();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule